// File: doc/BRIEF.md
# Link CRC Error Monitor

This block sits at the receive side of a serial link and checks every incoming symbol against the 4-bit CRC that travels with it. Each symbol's payload packs pixel data, the horizontal and vertical sync bits and control-channel bits into one word, and the CRC covers all of that word. When a check fails while the link PLL reports lock, the block pulls its active-low status output `link_good` low and keeps it there. That gives the host a level interrupt that persists until it is acknowledged.

Every failed check also bumps a 16-bit saturating error counter. Software reads the counter one byte at a time through a small read port. Reading the low byte captures the high byte in a shadow register, so a low-then-high read pair gives a consistent 16-bit value even while errors keep arriving. Losing PLL lock makes the status and the count meaningless, so while lock is low the block holds itself in its cleared state and ignores incoming symbols.

Top module: `link_crc_monitor`

## Requirements
- R1: The expected CRC is CRC-4 with generator x^4+x+1 (feedback mask 4'h3), initial value 0 and no final inversion. It is computed over the whole `sym_payload` word, most significant bit first. Payload 24'h000001 gives 4'h3 and payload 24'h000002 gives 4'h6.
- R2: A valid symbol whose `sym_crc` equals the computed CRC changes neither `link_good` nor the error count.
- R3: A valid symbol with a CRC mismatch while `pll_locked` is high drives `link_good` low from the following clock edge. It stays low through later good symbols until a clear or a loss of lock.
- R4: Each mismatching valid symbol while locked increments the error count by exactly one.
- R5: The error count saturates at 16'hFFFF. Further mismatches leave it there.
- R6: `clr_err` high while locked sets the count to 0 and `link_good` high at the next edge. A mismatch in that same cycle is still counted after the clear, giving a count of 1 and `link_good` low.
- R7: While `pll_locked` is low, the count and the high-byte shadow go to 0 and `link_good` goes high. Valid symbols in that time, whether good or bad, are ignored.
- R8: With `rd_en` high, `rd_addr` = 0 selects the low byte of the count and `rd_addr` = 1 selects the high-byte shadow. The value appears on `rd_data` one clock after the request. `rd_data` holds its value on cycles without `rd_en`.
- R9: A low-byte read latches the count's upper byte, taken from the same cycle as the low byte, into the shadow. A later high-byte read returns that latched value even if the count has changed since.
- R10: After reset, `link_good` is high, the count is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_locked | input | 1 | Receive PLL lock; checking is active only while high |
| sym_valid | input | 1 | A symbol is present this cycle |
| sym_payload | input | PAYLOAD_W | Symbol payload (pixel, sync and control bits) |
| sym_crc | input | 4 | CRC received with the symbol |
| clr_err | input | 1 | Clears the count and releases the status output |
| rd_en | input | 1 | Byte read request |
| rd_addr | input | 1 | Byte select: 0 low byte, 1 latched high byte |
| rd_data | output | 8 | Read data, one cycle after the request |
| link_good | output | 1 | Active-low error status, sticky low after a mismatch |

## Verification
The hardest states to reach are the ones that need a large error count. The shadow-coherence case needs a count above 255, and saturation needs 65,535 failures in a row. The stimulus gets there by streaming corrupted symbols back to back while locked. It first pushes the count past 0x100 and reads the low byte, then adds another 256 errors before the high-byte read, so a shadow that is not latched would show 0x02 instead of 0x01. It then clears and sends 65,540 corrupted symbols, so the counter sits at its ceiling for several cycles before both bytes are read.

// File: rtl/lcm_pkg.sv
package lcm_pkg;

    localparam int CRC_W  = 4;
    localparam logic [CRC_W-1:0] CRC_POLY = 4'h3;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic {
        RD_LO = 1'b0,
        RD_HI = 1'b1
    } rd_sel_e;

    // One serial CRC step, data bit fed in at the top of the register
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/lcm_crc4.sv
module lcm_crc4
    import lcm_pkg::*;
#(
    parameter int PAYLOAD_W = 24
) (
    input  logic [PAYLOAD_W-1:0] data,
    output logic [CRC_W-1:0]     crc
);

    // chain[i] is the remainder after the i most significant payload bits
    logic [CRC_W-1:0] chain [0:PAYLOAD_W];

    assign chain[0] = '0;

    generate
        for (genvar i = 0; i < PAYLOAD_W; i++) begin : g_bit
            assign chain[i+1] = crc_step(chain[i], data[PAYLOAD_W-1-i]);
        end
    endgenerate

    assign crc = chain[PAYLOAD_W];

endmodule

// File: rtl/lcm_err_counter.sv
module lcm_err_counter
    import lcm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             locked,
    input  logic             clr,
    input  logic             hit,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        if (!locked) begin
            cs_d.count = '0;
        end else begin
            if (clr) begin
                cs_d.count = '0;
            end
            if (hit && (cs_d.count != CNT_MAX)) begin
                cs_d.count = cs_d.count + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q <= '0;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign count = cs_q.count;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !clr && hit && (count != CNT_MAX)) |=> (count == $past(count) + CNT_W'(1))); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !clr && (count == CNT_MAX)) |=> (count == CNT_MAX)); // R5

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !clr && !hit) |=> $stable(count)); // R2

    AST_UNLOCK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |=> (count == '0)); // R7

endmodule

// File: rtl/lcm_byte_read.sv
module lcm_byte_read
    import lcm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              locked,
    input  logic              rd_en,
    input  rd_sel_e           rd_sel,
    input  logic [CNT_W-1:0]  count,
    output logic [BYTE_W-1:0] rd_data
);

    typedef struct packed {
        logic [BYTE_W-1:0] rd_data;
        logic [BYTE_W-1:0] shadow;
    } rd_state_t;

    rd_state_t rs_d, rs_q;

    always_comb begin
        rs_d = rs_q;
        if (rd_en) begin
            if (rd_sel == RD_LO) begin
                rs_d.rd_data = count[BYTE_W-1:0];
                rs_d.shadow  = count[CNT_W-1:BYTE_W];
            end else begin
                rs_d.rd_data = rs_q.shadow;
            end
        end
        if (!locked) begin
            rs_d.shadow = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign rd_data = rs_q.rd_data;

    AST_LO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == RD_LO) |=> (rd_data == $past(count[BYTE_W-1:0]))); // R8

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data)); // R8

    AST_SHADOW_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && rd_en && rd_sel == RD_LO) |=> (rs_q.shadow == $past(count[CNT_W-1:BYTE_W]))); // R9

endmodule

// File: rtl/link_crc_monitor.sv
module link_crc_monitor
    import lcm_pkg::*;
#(
    parameter int PAYLOAD_W = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pll_locked,
    input  logic                 sym_valid,
    input  logic [PAYLOAD_W-1:0] sym_payload,
    input  logic [CRC_W-1:0]     sym_crc,
    input  logic                 clr_err,
    input  logic                 rd_en,
    input  logic                 rd_addr,
    output logic [BYTE_W-1:0]    rd_data,
    output logic                 link_good
);

    logic [CRC_W-1:0] crc_calc;
    logic             crc_bad;
    logic [CNT_W-1:0] err_count;

    lcm_crc4 #(.PAYLOAD_W(PAYLOAD_W)) u_crc (
        .data (sym_payload),
        .crc  (crc_calc)
    );

    assign crc_bad = sym_valid && (crc_calc != sym_crc);

    typedef struct packed {
        logic good;
    } stat_state_t;

    stat_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!pll_locked) begin
            st_d.good = 1'b1;
        end else begin
            if (clr_err) begin
                st_d.good = 1'b1;
            end
            if (crc_bad) begin
                st_d.good = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{good: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign link_good = st_q.good;

    lcm_err_counter u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .locked (pll_locked),
        .clr    (clr_err),
        .hit    (crc_bad),
        .count  (err_count)
    );

    lcm_byte_read u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .locked  (pll_locked),
        .rd_en   (rd_en),
        .rd_sel  (rd_sel_e'(rd_addr)),
        .count   (err_count),
        .rd_data (rd_data)
    );

    AST_MISMATCH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_locked && crc_bad) |=> !link_good); // R3

    AST_STICKY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_locked && !clr_err && !link_good) |=> !link_good); // R3

    AST_MATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_locked && !clr_err && !crc_bad) |=> $stable(link_good)); // R2

    AST_CLEAR_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_locked && clr_err && !crc_bad) |=> link_good); // R6

    AST_UNLOCK_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_locked |=> link_good); // R7

endmodule

// File: tb/link_crc_monitor_test.sv
module link_crc_monitor_test;

    localparam int PW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pll_locked = 1'b0;
    logic          sym_valid = 1'b0;
    logic [PW-1:0] sym_payload = '0;
    logic [3:0]    sym_crc = '0;
    logic          clr_err = 1'b0;
    logic          rd_en = 1'b0;
    logic          rd_addr = 1'b0;
    logic [7:0]    rd_data;
    logic          link_good;

    always #5 clk = ~clk;

    link_crc_monitor #(.PAYLOAD_W(PW)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pll_locked  (pll_locked),
        .sym_valid   (sym_valid),
        .sym_payload (sym_payload),
        .sym_crc     (sym_crc),
        .clr_err     (clr_err),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .link_good   (link_good)
    );

    typedef struct {
        logic [7:0] rd;
        logic       good;
        string      tag;
    } exp_t;

    exp_t sb[$];
    int   n_cmp = 0;
    int   n_bad = 0;

    // Reference model state, derived from the requirements
    logic [15:0] m_cnt = '0;
    logic [7:0]  m_shadow = '0;
    logic [7:0]  m_rd = '0;
    logic        m_good = 1'b1;

    function automatic logic [3:0] ref_crc(input logic [PW-1:0] p);
        logic [3:0] r;
        r = 4'h0;
        for (int i = PW - 1; i >= 0; i--) begin
            if (r[3] ^ p[i]) r = {r[2:0], 1'b0} ^ 4'h3;
            else             r = {r[2:0], 1'b0};
        end
        return r;
    endfunction

    task automatic step_raw(input bit v, input logic [PW-1:0] p, input logic [3:0] c,
                            input bit lk, input bit clr, input bit rde, input bit hi,
                            input string tag);
        exp_t e;
        bit   bad;
        @(negedge clk);
        sym_valid = v; sym_payload = p; sym_crc = c;
        pll_locked = lk; clr_err = clr; rd_en = rde; rd_addr = hi;
        bad = v && (c != ref_crc(p));
        if (rde) begin
            if (!hi) begin
                m_rd = m_cnt[7:0];
                m_shadow = m_cnt[15:8];
            end else begin
                m_rd = m_shadow;
            end
        end
        if (!lk) begin
            m_cnt = '0; m_good = 1'b1; m_shadow = '0;
        end else begin
            if (clr) begin m_cnt = '0; m_good = 1'b1; end
            if (bad) begin
                m_good = 1'b0;
                if (m_cnt != 16'hFFFF) m_cnt = m_cnt + 16'd1;
            end
        end
        e.rd = m_rd; e.good = m_good; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic step(input bit v, input logic [PW-1:0] p, input bit corrupt,
                        input bit lk, input bit clr, input bit rde, input bit hi,
                        input string tag);
        step_raw(v, p, ref_crc(p) ^ (corrupt ? 4'h5 : 4'h0), lk, clr, rde, hi, tag);
    endtask

    task automatic bad_burst(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1, PW'(i * 37 + 11), 1, 1, 0, 0, 0, tag);
    endtask

    task automatic rd(input bit hi, input string tag);
        step(0, '0, 0, 1, 0, 1, hi, tag);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Monitor: compares each expectation against the outputs after its edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                n_cmp++;
                if (rd_data !== e.rd) begin
                    n_bad++;
                    $display("FAIL %s rd_data: actual %02h expected %02h", e.tag, rd_data, e.rd);
                end
                n_cmp++;
                if (link_good !== e.good) begin
                    n_bad++;
                    $display("FAIL %s link_good: actual %0b expected %0b", e.tag, link_good, e.good);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state seen at the ports
        step(0, '0, 0, 1, 0, 0, 0, "R10");

        // R1: fixed reference vectors, written out literally
        n_cmp++;
        if (ref_crc(24'h000001) !== 4'h3 || ref_crc(24'h000002) !== 4'h6) begin
            n_bad++;
            $display("FAIL R1 ref crc: actual %h/%h expected 3/6",
                     ref_crc(24'h000001), ref_crc(24'h000002));
        end
        step_raw(1, 24'h000001, 4'h3, 1, 0, 0, 0, "R1");
        step_raw(1, 24'h000002, 4'h6, 1, 0, 0, 0, "R1");

        // R2: varied good symbols
        for (int k = 0; k < 8; k++) step(1, PW'(32'hA53C0F * (k + 1) ^ (k << 20)), 0, 1, 0, 0, 0, "R2");
        step(1, '1, 0, 1, 0, 0, 0, "R2");
        rd(0, "R2");
        rd(1, "R8");

        // R3: mismatch then sticky through good symbols
        step_raw(1, 24'h000002, 4'h3, 1, 0, 0, 0, "R3");
        for (int k = 0; k < 5; k++) step(1, PW'(k * 1234567), 0, 1, 0, 0, 0, "R3");
        rd(0, "R4");
        bad_burst(3, "R4");
        rd(0, "R4");
        step(0, '0, 0, 1, 0, 0, 0, "R8");

        // R6: clear, then clear together with a mismatch
        step(0, '0, 0, 1, 1, 0, 0, "R6");
        rd(0, "R6");
        step(1, 24'h123456, 1, 1, 1, 0, 0, "R6");
        rd(0, "R6");

        // R7: unlocked, bad symbols ignored, state cleared
        bad_burst(2, "R7");
        for (int k = 0; k < 4; k++) step(1, PW'(k + 5), 1, 0, 0, 0, 0, "R7");
        step(1, 24'h00FF00, 0, 0, 0, 0, 0, "R7");
        step(0, '0, 0, 1, 0, 0, 0, "R7");
        rd(0, "R7");

        // R9: shadow coherence across 256 further errors
        bad_burst(300, "R4");
        rd(0, "R9");
        bad_burst(256, "R4");
        rd(1, "R9");
        rd(0, "R8");
        rd(1, "R8");

        // R7: lock loss clears the shadow
        step(0, '0, 0, 0, 0, 0, 0, "R7");
        rd(1, "R7");

        // R5: saturation
        step(0, '0, 0, 1, 1, 0, 0, "R6");
        bad_burst(65540, "R5");
        rd(0, "R5");
        rd(1, "R5");
        step(1, 24'h0ABCDE, 1, 1, 0, 1, 0, "R5");
        rd(1, "R5");

        repeat (4) @(negedge clk);
        summary();
    end

endmodule